// File: doc/BRIEF.md
# Multi-Mode Path Trace Monitor

This block watches the path trace overhead byte that arrives once per frame. Each arriving byte is flagged by a one-cycle frame strobe. The block stores the bytes in a 64-entry capture buffer, which a host reads through a plain combinational read port. In the comparing modes the block also keeps a trace-mismatch state.

A 3-bit mode input selects one of four behaviours:

- **Raw capture (000):** every byte is stored. Each byte is compared with the byte received 16 frames earlier.
- **SONET framing (001):** a 0x0A marker aligns a 64-byte message.
- **SDH framing (010):** a byte with its top bit set aligns a 16-byte message.
- **Persistence filter (011):** a byte is accepted into entry 0 once it has been seen unchanged for a programmable number of frames.

The codes 100 to 111 leave the block idle. Changes are reported by a sticky delta bit, and a mask input gates that bit onto an interrupt output.

The byte stream has no back-pressure. The frame strobe acts as the valid signal, and the block takes a byte on every cycle in which the strobe is high, so no ready signal exists. A byte whose strobe falls in the first cycle after a mode change is dropped.

Top module: `trace_monitor`

## Requirements
- R1: In mode 000, the n-th strobed byte after reset or mode entry is written to buffer address n mod 64. Addresses run 0, 1, 2, … and wrap from 63 to 0.
- R2: In mode 000, once 16 bytes have been stored, each strobed byte is compared with the byte stored 16 strobes earlier. A difference sets the mismatch output and a match clears it. Before that point the mismatch output is left unchanged.
- R3: In mode 001, nothing is written until a 0x0A byte arrives. The marker itself is not stored. The next byte goes to address 0 and later bytes follow at consecutive addresses, wrapping from 63 to 0.
- R4: In mode 001, once 64 message bytes have been written, each byte is compared with the content already held at its address. A difference sets the mismatch output and a match clears it.
- R5: In mode 010, a byte with bit 7 set is the marker. The next byte goes to address 1, and addresses wrap from 15 to 0. Comparing starts after 16 writes and follows the R4 rule.
- R6: In mode 011, a byte that differs from buffer entry 0 is written there once it has arrived in N consecutive strobes. N is the persistence input, and a value of 0 means 1. A byte equal to entry 0 restarts the count.
- R7: In mode 011, the mismatch output keeps its value, and each accepted byte sets the delta bit.
- R8: The delta bit is set in any cycle in which the mismatch output changes. It stays set until a cycle in which the clear input is high and no new set occurs. A set takes priority over a clear.
- R9: The interrupt output equals the delta bit when the mask input is 0, and is 0 when the mask input is 1.
- R10: A change of the mode input restarts framing, the write pointer, the fill count and the persistence count, and drops a strobe in the same cycle. Modes 100 to 111 ignore strobes.
- R11: After reset the mismatch output, the delta bit and the interrupt output are 0, and every buffer entry reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Monitoring mode select |
| persist_lim | input | 4 | Consecutive-frame count for mode 011 (0 means 1) |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| delta_clr | input | 1 | Clears the sticky delta bit |
| frm_stb | input | 1 | Frame strobe; marks a valid trace byte |
| trc_byte | input | 8 | Received path trace byte |
| rd_addr | input | 6 | Host read address into the capture buffer |
| rd_data | output | 8 | Buffer content at rd_addr (combinational) |
| mism | output | 1 | Trace mismatch state |
| delta | output | 1 | Sticky change indication |
| irq | output | 1 | Masked interrupt |

## Verification
Several properties are checked by assertions on every cycle:

- the delta bit rises whenever the mismatch output changes;
- the interrupt never rises without delta;
- the mismatch output holds steady in the persistence mode;
- the SDH write address stays below 16;
- the pointer wraps and realigns correctly after a marker;
- a mode change clears the framing and the persistence counts;
- an accepted byte always differs from the stored one.

Other behaviour can only be shown by the bench's scenarios, because it depends on the history of stored bytes:

- which history entry a byte is compared against;
- that stored contents land at the right addresses;
- that compares are held off until the buffer is full;
- that persistence counts restart on a repeat of the accepted byte.

// File: rtl/trace_mon_pkg.sv
package trace_mon_pkg;
  localparam logic [2:0] TM_RAW     = 3'b000;
  localparam logic [2:0] TM_SONET   = 3'b001;
  localparam logic [2:0] TM_SDH     = 3'b010;
  localparam logic [2:0] TM_PERSIST = 3'b011;
  localparam logic [7:0] SONET_MARK = 8'h0A;
endpackage

// File: rtl/trace_buf.sv
module trace_buf #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/trace_framer.sv
module trace_framer
  import trace_mon_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int SHORT_LEN = 16,
  parameter int W         = 8,
  localparam int AW       = $clog2(BUF_DEPTH),
  localparam int CW       = $clog2(BUF_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic          restart,
  input  logic          stb,
  input  logic [W-1:0]  byte_in,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          cmp_en,
  output logic [AW-1:0] cmp_addr
);
  localparam logic [CW-1:0] FILL_LONG  = CW'(BUF_DEPTH);
  localparam logic [CW-1:0] FILL_SHORT = CW'(SHORT_LEN);
  localparam logic [AW-1:0] LAST_LONG  = AW'(BUF_DEPTH - 1);
  localparam logic [AW-1:0] LAST_SHORT = AW'(SHORT_LEN - 1);
  localparam logic [AW-1:0] LAG        = AW'(SHORT_LEN);

  logic          framed;
  logic [AW-1:0] ptr;
  logic [CW-1:0] fill;

  logic is_raw, is_sonet, is_sdh, is_framing, marker, may_write;
  logic [AW-1:0] last;
  logic [CW-1:0] fill_need;

  always_comb begin
    is_raw     = (mode == TM_RAW);
    is_sonet   = (mode == TM_SONET);
    is_sdh     = (mode == TM_SDH);
    is_framing = is_sonet | is_sdh;
    marker     = is_sonet ? (byte_in == SONET_MARK) : byte_in[W-1];
    last       = is_sdh ? LAST_SHORT : LAST_LONG;
    fill_need  = is_sonet ? FILL_LONG : FILL_SHORT;
    may_write  = is_raw | (is_framing & framed);
    wr_en      = stb & ~restart & may_write;
    wr_addr    = ptr;
    cmp_en     = wr_en & (fill >= fill_need);
    cmp_addr   = is_raw ? (ptr - LAG) : ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      framed <= 1'b0;
      ptr    <= '0;
      fill   <= '0;
    end else if (stb) begin
      if (is_framing && !framed) begin
        if (marker) begin
          framed <= 1'b1;
          ptr    <= is_sdh ? AW'(1) : '0;
        end
      end else if (wr_en) begin
        ptr <= (ptr == last) ? '0 : ptr + AW'(1);
        if (fill != FILL_LONG) fill <= fill + CW'(1);
      end
    end
  end

  // R5: SDH messages live in the first SHORT_LEN entries
  assert_sdh_addr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_sdh) |-> (wr_addr < LAG));

  // R1/R3: pointer returns to zero after the last position
  assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == last) |=> (ptr == '0));

  // R3/R5: first position after marker
  assert_first_pos_after_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(framed) |-> (ptr == (($past(mode) == TM_SDH) ? AW'(1) : AW'(0))));

  // R10: mode change clears framing and fill
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!framed && fill == '0 && ptr == '0));
endmodule

// File: rtl/trace_persist.sv
module trace_persist #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          en,
  input  logic [W-1:0]  byte_in,
  input  logic [W-1:0]  accepted,
  input  logic [CW-1:0] limit,
  output logic          accept
);
  logic [W-1:0]  cand;
  logic [CW-1:0] run;
  logic [CW-1:0] lim_eff, run_nxt;
  logic          same_acc, cont;

  always_comb begin
    lim_eff  = (limit == '0) ? CW'(1) : limit;
    same_acc = (byte_in == accepted);
    cont     = (run != '0) && (byte_in == cand);
    run_nxt  = cont ? run + CW'(1) : CW'(1);
    accept   = en & ~same_acc & (run_nxt >= lim_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cand <= '0;
      run  <= '0;
    end else if (en) begin
      if (same_acc || accept) begin
        run <= '0;
      end else begin
        cand <= byte_in;
        run  <= run_nxt;
      end
    end
  end

  // R6: only a byte different from the stored one is accepted
  assert_accept_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (byte_in != accepted));

  // R10: mode change clears the persistence count
  assert_persist_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (run == '0));
endmodule

// File: rtl/trace_monitor.sv
module trace_monitor
  import trace_mon_pkg::*;
#(
  parameter int W         = 8,
  parameter int BUF_DEPTH = 64,
  parameter int SHORT_LEN = 16,
  parameter int CNT_W     = 4,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] persist_lim,
  input  logic             irq_mask,
  input  logic             delta_clr,
  input  logic             frm_stb,
  input  logic [W-1:0]     trc_byte,
  input  logic [AW-1:0]    rd_addr,
  output logic [W-1:0]     rd_data,
  output logic             mism,
  output logic             delta,
  output logic             irq
);
  logic [2:0]    mode_q;
  logic          restart, is_persist;
  logic          fr_wr_en, fr_cmp_en, acc;
  logic [AW-1:0] fr_wr_addr, fr_cmp_addr;
  logic          buf_we;
  logic [AW-1:0] buf_waddr, buf_caddr;
  logic [W-1:0]  cmp_data;
  logic          mism_nxt;

  assign restart    = (mode != mode_q);
  assign is_persist = (mode == TM_PERSIST);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= TM_RAW;
    else        mode_q <= mode;
  end

  trace_framer #(.BUF_DEPTH(BUF_DEPTH), .SHORT_LEN(SHORT_LEN), .W(W)) u_framer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .restart(restart),
    .stb(frm_stb), .byte_in(trc_byte),
    .wr_en(fr_wr_en), .wr_addr(fr_wr_addr),
    .cmp_en(fr_cmp_en), .cmp_addr(fr_cmp_addr)
  );

  trace_persist #(.W(W), .CW(CNT_W)) u_persist (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .en(frm_stb & is_persist & ~restart),
    .byte_in(trc_byte), .accepted(cmp_data),
    .limit(persist_lim), .accept(acc)
  );

  assign buf_we    = fr_wr_en | acc;
  assign buf_waddr = acc ? '0 : fr_wr_addr;
  assign buf_caddr = is_persist ? '0 : fr_cmp_addr;

  trace_buf #(.DEPTH(BUF_DEPTH), .W(W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .we(buf_we), .waddr(buf_waddr), .wdata(trc_byte),
    .raddr_a(rd_addr), .rdata_a(rd_data),
    .raddr_b(buf_caddr), .rdata_b(cmp_data)
  );

  assign mism_nxt = fr_cmp_en ? (trc_byte != cmp_data) : mism;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mism  <= 1'b0;
      delta <= 1'b0;
    end else begin
      mism <= mism_nxt;
      if ((mism_nxt != mism) || acc) delta <= 1'b1;
      else if (delta_clr)            delta <= 1'b0;
    end
  end

  assign irq = delta & ~irq_mask;

  // R8: every change of the mismatch state leaves delta set
  assert_delta_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mism != $past(mism)) |-> delta);

  // R9: interrupt never active without delta or while masked
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (delta && !irq_mask));

  // R7: persistence mode leaves the mismatch state alone
  assert_mism_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_persist && $past(mode) == TM_PERSIST) |-> $stable(mism));
endmodule

// File: tb/trace_monitor_bench.sv
module trace_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic [3:0] persist_lim;
  logic       irq_mask, delta_clr, frm_stb;
  logic [7:0] trc_byte;
  logic [5:0] rd_addr;
  logic [7:0] rd_data;
  logic       mism, delta, irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_monitor u_trace_monitor (
    .clk(clk), .rst_n(rst_n), .mode(mode), .persist_lim(persist_lim),
    .irq_mask(irq_mask), .delta_clr(delta_clr), .frm_stb(frm_stb),
    .trc_byte(trc_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .mism(mism), .delta(delta), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] b;
    logic       clr;
    logic       em;
    logic       ed;
  } vec_t;

  // raw-mode compare phase; entries k compare with 0x40+k (R2, R8)
  localparam vec_t VECS [8] = '{
    '{8'h40, 1'b0, 1'b0, 1'b0},
    '{8'h41, 1'b0, 1'b0, 1'b0},
    '{8'h99, 1'b0, 1'b1, 1'b1},
    '{8'h55, 1'b1, 1'b1, 1'b0},
    '{8'h44, 1'b0, 1'b0, 1'b1},
    '{8'h45, 1'b1, 1'b0, 1'b0},
    '{8'h46, 1'b0, 1'b0, 1'b0},
    '{8'h00, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic strobe(input logic [7:0] b, input logic clr);
    @(negedge clk);
    frm_stb = 1'b1; trc_byte = b; delta_clr = clr;
    @(negedge clk);
    frm_stb = 1'b0; delta_clr = 1'b0;
  endtask

  task automatic clear_delta();
    @(negedge clk);
    delta_clr = 1'b1;
    @(negedge clk);
    delta_clr = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL all requirements: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 3'b000; persist_lim = 4'd1; irq_mask = 1'b0;
    delta_clr = 1'b0; frm_stb = 1'b0; trc_byte = 8'h00; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 mism", {7'b0, mism}, 8'h0);
    chk("R11 delta", {7'b0, delta}, 8'h0);
    chk("R11 irq", {7'b0, irq}, 8'h0);
    rdchk("R11 buffer", 6'd5, 8'h00);

    // R1 raw fill, no compares yet (R2)
    for (int i = 0; i < 16; i++) strobe(8'h40 + 8'(i), 1'b0);
    chk("R2 no compare before 16", {7'b0, mism}, 8'h0);
    chk("R2 no delta before 16", {7'b0, delta}, 8'h0);
    rdchk("R1 addr3", 6'd3, 8'h43);

    // R2/R8 vector table
    for (int k = 0; k < 8; k++) begin
      strobe(VECS[k].b, VECS[k].clr);
      chk($sformatf("R2 mism vec%0d", k), {7'b0, mism}, {7'b0, VECS[k].em});
      chk($sformatf("R8 delta vec%0d", k), {7'b0, delta}, {7'b0, VECS[k].ed});
    end
    rdchk("R1 addr18", 6'd18, 8'h99);

    // R9 masking
    irq_mask = 1'b0; #1;
    chk("R9 irq unmasked", {7'b0, irq}, 8'h1);
    irq_mask = 1'b1; #1;
    chk("R9 irq masked", {7'b0, irq}, 8'h0);
    irq_mask = 1'b0;

    // R1 wrap: writes 24..63 then address 0
    for (int i = 0; i < 40; i++) strobe(8'h70, 1'b0);
    strobe(8'hEE, 1'b0);
    rdchk("R1 wrap addr0", 6'd0, 8'hEE);
    rdchk("R1 addr63", 6'd63, 8'h70);
    chk("R2 mismatch vs 16 back", {7'b0, mism}, 8'h1);
    clear_delta();

    // R10 idle mode ignores strobes
    set_mode(3'b100);
    strobe(8'h12, 1'b0);
    rdchk("R10 idle no write", 6'd1, 8'h41);

    // R3 SONET framing
    set_mode(3'b001);
    strobe(8'h33, 1'b0);
    rdchk("R3 unframed no write", 6'd0, 8'hEE);
    strobe(8'h0A, 1'b0);
    rdchk("R3 marker not stored", 6'd0, 8'hEE);
    for (int i = 0; i < 64; i++) strobe(8'h80 + 8'(i), 1'b0);
    rdchk("R3 first byte at 0", 6'd0, 8'h80);
    rdchk("R3 last byte at 63", 6'd63, 8'hBF);
    chk("R4 held during first pass", {7'b0, mism}, 8'h1);
    strobe(8'h80, 1'b0);
    chk("R4 match clears", {7'b0, mism}, 8'h0);
    chk("R8 delta on clear", {7'b0, delta}, 8'h1);
    strobe(8'h00, 1'b0);
    chk("R4 mismatch sets", {7'b0, mism}, 8'h1);

    // R5 SDH framing
    set_mode(3'b010);
    clear_delta();
    strobe(8'h05, 1'b0);
    strobe(8'h80, 1'b0);
    for (int i = 0; i < 16; i++) strobe(8'h10 + 8'(i), 1'b0);
    rdchk("R5 byte after marker at 1", 6'd1, 8'h10);
    rdchk("R5 addr15", 6'd15, 8'h1E);
    rdchk("R5 wrap to 0", 6'd0, 8'h1F);
    rdchk("R5 addr16 untouched", 6'd16, 8'h90);
    strobe(8'h10, 1'b0);
    chk("R5 compare match", {7'b0, mism}, 8'h0);
    strobe(8'h11, 1'b0);
    chk("R5 next match", {7'b0, mism}, 8'h0);

    // R6/R7 persistence
    set_mode(3'b011);
    persist_lim = 4'd3;
    clear_delta();
    strobe(8'h5A, 1'b0);
    strobe(8'h5A, 1'b0);
    rdchk("R6 not yet accepted", 6'd0, 8'h1F);
    chk("R7 no delta before accept", {7'b0, delta}, 8'h0);
    strobe(8'h5A, 1'b0);
    rdchk("R6 accepted after 3", 6'd0, 8'h5A);
    chk("R7 delta on accept", {7'b0, delta}, 8'h1);
    chk("R7 mism unchanged", {7'b0, mism}, 8'h0);
    clear_delta();
    strobe(8'h66, 1'b0);
    strobe(8'h66, 1'b0);
    strobe(8'h5A, 1'b0);
    strobe(8'h66, 1'b0);
    strobe(8'h66, 1'b0);
    rdchk("R6 repeat of stored restarts", 6'd0, 8'h5A);
    strobe(8'h66, 1'b0);
    rdchk("R6 accepted 66", 6'd0, 8'h66);
    persist_lim = 4'd0;
    strobe(8'h77, 1'b0);
    rdchk("R6 zero limit means one", 6'd0, 8'h77);

    // R10 mode change restarts persistence
    persist_lim = 4'd2;
    strobe(8'h31, 1'b0);
    set_mode(3'b100);
    set_mode(3'b011);
    strobe(8'h31, 1'b0);
    rdchk("R10 persistence restarted", 6'd0, 8'h77);
    strobe(8'h31, 1'b0);
    rdchk("R10 accepted after restart", 6'd0, 8'h31);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule